// File: doc/BRIEF.md
# Logarithmic Programmable Shifter

This block moves a data word left or right by a binary count, in a chain of power-of-two stages. Stage k takes the word from the stage before it and either moves it by 2^k places or hands it on untouched. Bit k of the encoded count drives stage k directly, so the count never passes through a decoder. The chain is only log2(WIDTH) stages deep, and a shift costs the same logic depth whatever its distance.

Every stage reads the same three controls. A direction bit picks left or right. A two-bit kind code picks how the vacated places are filled: with zeros (logical), with the sign bit on right moves (arithmetic), or with the bits that fall off the far end (circular). A parameter can place an output register after the chain. The register is on by default, which gives a result one clock after the inputs are applied.

Top module: `stepped_shifter`

## Requirements
- R1: With amount `a` (0 to WIDTH-1), the result equals one shift by the full distance `a`, built from the stages for the set bits of `a`. Bit k of `amt` selects a move of 2^k places.
- R2: With `dir_right`=0 and `kind`=2'b00 (logical), the result is `din << amt` and vacated low bits are 0.
- R3: With `dir_right`=1 and `kind`=2'b00, the result is `din >> amt` and vacated high bits are 0.
- R4: With `dir_right`=1 and `kind`=2'b01 (arithmetic), vacated high bits take the value of `din[WIDTH-1]`, as in a signed `>>>`.
- R5: With `dir_right`=0 and `kind`=2'b01, the result equals the logical left shift (zero fill).
- R6: With `kind`=2'b10 (circular), bits that leave one end come back in at the other, in both directions, and the number of ones is unchanged.
- R7: `kind`=2'b11 gives exactly the logical result for either direction.
- R8: `amt`=0 returns `din` unchanged for every kind and direction.
- R9: With `OUT_REG`=1 (default), `dout` shows the result for the inputs sampled at a rising edge of `clk` from that edge on. While `rst_n` is low, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low reset, clears the output register |
| din | input | WIDTH | Word to be shifted |
| amt | input | log2(WIDTH) | Binary shift distance; bit k drives stage k |
| dir_right | input | 1 | 0 = left, 1 = right |
| kind | input | 2 | 00 logical, 01 arithmetic, 10 circular, 11 logical |
| dout | output | WIDTH | Shifted word (registered when OUT_REG=1) |

## Verification
The checker tests the invariants of the unregistered chain on every clock cycle. A zero count passes the word through, and a rotate keeps the number of ones. An arithmetic right shift keeps the sign bit, and a logical or left shift clears the vacated end bit. It also checks that the output register carries the previous cycle's result. Only the bench's scenarios can show that each shift value is correct bit for bit. The bench sweeps every data word, distance, direction and kind against reference operators, and checks the one-cycle latency and the reset value of the output.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [1:0] {
    KIND_LOGIC  = 2'b00,
    KIND_ARITH  = 2'b01,
    KIND_ROTATE = 2'b10,
    KIND_SPARE  = 2'b11
  } shift_kind_e;

  // The spare code behaves as logical; only the two named codes change the fill.
  function automatic logic kind_is_rotate(input logic [1:0] k);
    return k == KIND_ROTATE;
  endfunction

  function automatic logic kind_is_arith(input logic [1:0] k);
    return k == KIND_ARITH;
  endfunction

  // Bit used to fill vacated places on a non-circular move.
  function automatic logic fill_value(input logic [1:0] k, input logic right, input logic sign);
    return kind_is_arith(k) & right & sign;
  endfunction

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl (
  input  logic [1:0] kind,
  input  logic       dir_right,
  input  logic       sign_bit,
  output logic       rotate_en,
  output logic       fill_bit
);
  import shifter_pkg::*;

  always_comb begin
    rotate_en = kind_is_rotate(kind);
    fill_bit  = fill_value(kind, dir_right, sign_bit);
  end

endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int WIDTH = 8,
  parameter int DIST  = 1
) (
  input  logic [WIDTH-1:0] word_in,
  input  logic             en,
  input  logic             dir_right,
  input  logic             rotate_en,
  input  logic             fill_bit,
  output logic [WIDTH-1:0] word_out
);
  logic [DIST-1:0]  left_in_bits;
  logic [DIST-1:0]  right_in_bits;
  logic [WIDTH-1:0] moved_left;
  logic [WIDTH-1:0] moved_right;

  always_comb begin
    left_in_bits  = rotate_en ? word_in[WIDTH-1 -: DIST] : {DIST{1'b0}};
    right_in_bits = rotate_en ? word_in[DIST-1:0] : {DIST{fill_bit}};
    moved_left    = {word_in[WIDTH-1-DIST:0], left_in_bits};
    moved_right   = {right_in_bits, word_in[WIDTH-1:DIST]};
    if (!en)            word_out = word_in;
    else if (dir_right) word_out = moved_right;
    else                word_out = moved_left;
  end

endmodule

// File: rtl/out_stage.sv
module out_stage #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
      end
    end else begin : g_wire
      logic unused_ctl;
      assign unused_ctl = clk ^ rst_n;
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/stepped_shifter.sv
module stepped_shifter #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int AW     = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  input  logic [AW-1:0]    amt,
  input  logic             dir_right,
  input  logic [1:0]       kind,
  output logic [WIDTH-1:0] dout
);
  localparam int STAGES = AW;

  logic             rotate_en;
  logic             fill_bit;
  logic [WIDTH-1:0] stage_word [0:STAGES];
  logic [WIDTH-1:0] comb_result;

  shift_ctrl u_ctrl (
    .kind      (kind),
    .dir_right (dir_right),
    .sign_bit  (din[WIDTH-1]),
    .rotate_en (rotate_en),
    .fill_bit  (fill_bit)
  );

  assign stage_word[0] = din;

  generate
    for (genvar k = 0; k < STAGES; k++) begin : g_stage
      shift_stage #(.WIDTH(WIDTH), .DIST(1 << k)) u_stage (
        .word_in   (stage_word[k]),
        .en        (amt[k]),
        .dir_right (dir_right),
        .rotate_en (rotate_en),
        .fill_bit  (fill_bit),
        .word_out  (stage_word[k+1])
      );
    end
  endgenerate

  assign comb_result = stage_word[STAGES];

  out_stage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (comb_result),
    .q     (dout)
  );

endmodule

// File: rtl/stepped_shifter_chk.sv
module stepped_shifter_chk #(
  parameter int WIDTH   = 8,
  parameter bit OUT_REG = 1'b1,
  localparam int AW     = $clog2(WIDTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] din,
  input logic [AW-1:0]    amt,
  input logic             dir_right,
  input logic [1:0]       kind,
  input logic [WIDTH-1:0] comb_result,
  input logic [WIDTH-1:0] dout
);
  import shifter_pkg::*;

  // R8
  zero_amount_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    amt == '0 |-> comb_result == din);

  // R6
  rotate_ones_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kind == KIND_ROTATE |-> $countones(comb_result) == $countones(din));

  // R4
  arith_sign_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == KIND_ARITH && dir_right) |-> comb_result[WIDTH-1] == din[WIDTH-1]);

  // R2
  left_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != KIND_ROTATE && !dir_right && amt != '0) |-> comb_result[0] == 1'b0);

  // R3
  right_zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == KIND_LOGIC || kind == KIND_SPARE) && dir_right && amt != '0)
      |-> comb_result[WIDTH-1] == 1'b0);

  generate
    if (OUT_REG) begin : g_reg_chk
      // R9
      out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> dout == $past(comb_result));
    end else begin : g_comb_chk
      // R9
      out_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout == comb_result);
    end
  endgenerate

endmodule

bind stepped_shifter stepped_shifter_chk #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .din         (din),
  .amt         (amt),
  .dir_right   (dir_right),
  .kind        (kind),
  .comb_result (comb_result),
  .dout        (dout)
);

// File: tb/sim_stepped_shifter.sv
`timescale 1ns/1ps
module sim_stepped_shifter;
  localparam int W  = 8;
  localparam int AW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  din = '0;
  logic [AW-1:0] amt = '0;
  logic          dir_right = 1'b0;
  logic [1:0]    kind = 2'b00;
  logic [W-1:0]  dout;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    logic [W-1:0] exp;
    int           due;
    string        req;
  } item_t;

  item_t sb [$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  stepped_shifter #(.WIDTH(W), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .din(din), .amt(amt),
    .dir_right(dir_right), .kind(kind), .dout(dout)
  );

  function automatic logic [W-1:0] ref_shift(input logic [W-1:0] d, input int a,
                                             input logic r, input logic [1:0] k);
    logic [2*W-1:0] dbl;
    if (k == 2'b10) begin
      dbl = {d, d};
      if (r) begin dbl = dbl >> a; return dbl[W-1:0]; end
      dbl = dbl << a;
      return dbl[2*W-1:W];
    end
    if (k == 2'b01 && r) return W'($signed(d) >>> a);
    return r ? (d >> a) : (d << a);
  endfunction

  function automatic string req_of(input int a, input logic r, input logic [1:0] k);
    if (a == 0)      return "R1+R8+R9";
    if (k == 2'b11)  return "R1+R7+R9";
    if (k == 2'b10)  return "R1+R6+R9";
    if (k == 2'b01)  return r ? "R1+R4+R9" : "R1+R5+R9";
    return r ? "R1+R3+R9" : "R1+R2+R9";
  endfunction

  task automatic drive(input logic [W-1:0] d, input int a, input logic r, input logic [1:0] k);
    item_t it;
    @(negedge clk);
    din = d; amt = AW'(a); dir_right = r; kind = k;
    it.exp = ref_shift(d, a, r, k);
    it.due = cyc + 1;
    it.req = req_of(a, r, k);
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      compared++;
      if (dout !== it.exp) begin
        mismatched++;
        $display("FAIL %s din=%h amt=%0d right=%0b kind=%0d actual=%h expected=%h",
                 it.req, din, amt, dir_right, kind, dout, it.exp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    din = 8'hA5; amt = 3'd3; dir_right = 1'b1; kind = 2'b01;
    repeat (3) @(negedge clk);
    compared++;
    if (dout !== '0) begin
      mismatched++;
      $display("FAIL R9 reset output actual=%h expected=%h", dout, {W{1'b0}});
    end
    rst_n = 1'b1;
    for (int d = 0; d < (1 << W); d++)
      for (int k = 0; k < 4; k++)
        for (int r = 0; r < 2; r++)
          for (int a = 0; a < W; a++)
            drive(W'(d), a, r[0], k[1:0]);
    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      mismatched++;
      $display("FAIL R9 pending results actual=%0d expected=0", sb.size());
    end
    finish_run();
  end

endmodule